// File: doc/BRIEF.md
# Event Debounce Counter

This block qualifies a raw event condition before it is reported as an event flag. Each time the sample tick pulses (once per output-data sample), the block looks at the raw condition. A sample that shows the condition moves an internal counter up toward a programmable 8-bit debounce limit. The flag rises on the sample where the counter reaches that limit. The debounce time is therefore the limit times the sample period. For example, a limit of 15 at 100 samples per second gives 150 ms.

A sample that lacks the condition is handled in one of two ways, chosen by a mode input. In clear mode the counter returns to zero and the flag drops at once. In decrement mode the counter steps down by one and stops at zero. The flag then stays up until the counter reaches zero. This acts like a median filter: it rides through isolated spurious misses. A separate invalid-sequence input clears the counter and the flag at any time. Detection of the raw condition itself happens upstream.

Top module: `event_debounce`

## Requirements
- R1: With sample_tick low and seq_clear low, neither the counter nor event_flag changes, whatever raw_event does.
- R2: On a tick with raw_event high, the counter increments. event_flag is 1 after the tick on which the counter equals debounce_limit. For a limit N of 1 or more, starting from zero, this is after the Nth consecutive hit tick and not after the (N-1)th.
- R3: The counter saturates at debounce_limit and never wraps. After any number of extra hit ticks it holds the limit, including a limit of 255.
- R4: With decrement_mode = 0 (clear mode), a tick with raw_event low sets the counter to zero and event_flag to 0.
- R5: With decrement_mode = 1 (decrement mode), a tick with raw_event low lowers the counter by one, stopping at zero. event_flag stays as it was until the counter reaches zero, and then it drops to 0.
- R6: seq_clear high at a clock edge sets the counter to zero and event_flag to 0, with or without a tick, and takes priority over every other input.
- R7: With debounce_limit = 0, event_flag after each tick equals raw_event sampled on that tick, in both modes.
- R8: After reset, event_flag is 0 and the counter is zero, so a limit of N needs N hit ticks before the flag rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | One-cycle pulse per data sample; the counter only moves on it |
| raw_event | input | 1 | Raw event condition for the current sample |
| debounce_limit | input | CNT_W | Number of qualifying samples needed to raise the flag |
| decrement_mode | input | 1 | 1: a miss decrements the counter; 0: a miss clears it |
| seq_clear | input | 1 | Invalid-sequence clear of the counter and flag |
| event_flag | output | 1 | Debounced event flag |

## Verification
The bench sweeps limits 0 through 6 in both miss modes. Each setting runs pseudo-random hit/miss patterns, one biased toward hits and one balanced. A model in the bench predicts the flag after every tick. The biased patterns reach and overrun the limit, which exposes off-by-one errors in the rise and faults in saturation. The balanced patterns separate clear-on-miss from decrement-on-miss through the flag's release point. Directed runs add a limit of 255, an overrun followed by exactly limit-many misses (which shows saturation rather than wrap), ticks withheld while the condition toggles, and an invalid-sequence clear arriving between ticks.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;
  typedef enum logic {
    MISS_CLEAR = 1'b0,
    MISS_DECR  = 1'b1
  } miss_mode_e;
endpackage

// File: rtl/dbnc_counter.sv
module dbnc_counter
  import dbnc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             hit,
  input  miss_mode_e       mode,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt
);
  localparam logic [CNT_W-1:0] ZERO = '0;

  function automatic logic [CNT_W-1:0] step_up(input logic [CNT_W-1:0] c,
                                                input logic [CNT_W-1:0] l);
    return (c >= l) ? l : c + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] c);
    return (c == ZERO) ? ZERO : c - 1'b1;
  endfunction

  always_comb begin
    cnt_nxt = cnt_q;
    if (clr) begin
      cnt_nxt = ZERO;
    end else if (tick) begin
      if (hit)                    cnt_nxt = step_up(cnt_q, limit);
      else if (mode == MISS_DECR) cnt_nxt = step_down(cnt_q);
      else                        cnt_nxt = ZERO;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= ZERO;
    else        cnt_q <= cnt_nxt;
  end

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt_q)); // R1
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hit && !clr) |=> (cnt_q <= $past(limit))); // R3
  AST_CLEAR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !hit && !clr && mode == MISS_CLEAR) |=> (cnt_q == ZERO)); // R4
  AST_DECR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !hit && !clr && mode == MISS_DECR && cnt_q != ZERO)
      |=> (cnt_q == $past(cnt_q) - 1'b1)); // R5
  AST_SEQ_CLEAR_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == ZERO)); // R6
endmodule

// File: rtl/dbnc_flag.sv
module dbnc_flag
  import dbnc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             hit,
  input  miss_mode_e       mode,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [CNT_W-1:0] cnt_nxt,
  output logic             flag_q
);
  logic set_evt;
  logic drop_evt;
  logic flag_d;

  assign set_evt  = tick && hit && (cnt_nxt == limit);
  assign drop_evt = clr || (tick && !hit &&
                    ((mode == MISS_CLEAR) || (cnt_nxt == '0)));

  always_comb begin
    flag_d = flag_q;
    if (drop_evt)     flag_d = 1'b0;
    else if (set_evt) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  AST_FLAG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(flag_q)); // R1
  AST_FLAG_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hit && !clr && (cnt_q >= limit || cnt_q + 1'b1 == limit)) |=> flag_q); // R2
  AST_FLAG_CLEAR_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !hit && !clr && mode == MISS_CLEAR) |=> !flag_q); // R4
  AST_FLAG_DECR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !hit && !clr && mode == MISS_DECR && cnt_q > 1 && flag_q) |=> flag_q); // R5
  AST_FLAG_SEQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !flag_q); // R6
endmodule

// File: rtl/event_debounce.sv
module event_debounce
  import dbnc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_tick,
  input  logic             raw_event,
  input  logic [CNT_W-1:0] debounce_limit,
  input  logic             decrement_mode,
  input  logic             seq_clear,
  output logic             event_flag
);
  miss_mode_e       mode;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;

  assign mode = decrement_mode ? MISS_DECR : MISS_CLEAR;

  dbnc_counter #(.CNT_W(CNT_W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (sample_tick),
    .hit     (raw_event),
    .mode    (mode),
    .clr     (seq_clear),
    .limit   (debounce_limit),
    .cnt_q   (cnt_q),
    .cnt_nxt (cnt_nxt)
  );

  dbnc_flag #(.CNT_W(CNT_W)) u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (sample_tick),
    .hit     (raw_event),
    .mode    (mode),
    .clr     (seq_clear),
    .limit   (debounce_limit),
    .cnt_q   (cnt_q),
    .cnt_nxt (cnt_nxt),
    .flag_q  (event_flag)
  );

  AST_LIMIT0_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && !seq_clear && debounce_limit == '0)
      |=> (event_flag == $past(raw_event))); // R7
endmodule

// File: tb/event_debounce_tb.sv
module event_debounce_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sample_tick = 1'b0;
  logic       raw_event = 1'b0;
  logic [7:0] debounce_limit = 8'd0;
  logic       decrement_mode = 1'b0;
  logic       seq_clear = 1'b0;
  logic       event_flag;

  int         n_tests = 0;
  int         n_fail = 0;
  int         m_cnt = 0;
  bit         m_flag = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  event_debounce #(.CNT_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .raw_event(raw_event),
    .debounce_limit(debounce_limit), .decrement_mode(decrement_mode),
    .seq_clear(seq_clear), .event_flag(event_flag)
  );

  task automatic check(input string tag, input bit exp);
    n_tests++;
    if (event_flag !== exp) begin
      n_fail++;
      $display("FAIL %s: event_flag=%b expected=%b (limit=%0d mode=%0d)",
               tag, event_flag, exp, debounce_limit, decrement_mode);
    end
  endtask

  task automatic model_step(input bit c);
    int lim;
    lim = int'(debounce_limit);
    if (c) begin
      m_cnt = (m_cnt + 1 > lim) ? lim : m_cnt + 1;
      if (m_cnt == lim) m_flag = 1'b1;
    end else if (decrement_mode) begin
      m_cnt = (m_cnt > 0) ? m_cnt - 1 : 0;
      if (m_cnt == 0) m_flag = 1'b0;
    end else begin
      m_cnt = 0;
      m_flag = 1'b0;
    end
  endtask

  task automatic do_tick(input bit c, input string tag);
    @(negedge clk);
    raw_event = c;
    sample_tick = 1'b1;
    @(negedge clk);
    sample_tick = 1'b0;
    model_step(c);
    check(tag, m_flag);
  endtask

  task automatic do_clear();
    @(negedge clk);
    seq_clear = 1'b1;
    @(negedge clk);
    seq_clear = 1'b0;
    m_cnt = 0;
    m_flag = 1'b0;
    check("R6 seq_clear", 1'b0);
  endtask

  function automatic logic [15:0] lfsr_next(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  initial begin
    #400000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset flag", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 after reset", 1'b0);

    // R8: limit 2 from reset needs two hit ticks
    debounce_limit = 8'd2;
    do_tick(1'b1, "R8 first hit");
    do_tick(1'b1, "R2 second hit");

    // R1: no tick, raw toggles, flag stays
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      raw_event = i[0];
      check("R1 no tick", m_flag);
    end
    do_tick(1'b0, "R4 drop");
    debounce_limit = 8'd0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      raw_event = 1'b1;
      check("R1 no tick limit0", 1'b0);
    end

    // Sweep limits and modes with two hit densities
    for (int md = 0; md < 2; md++) begin
      for (int lim = 0; lim < 7; lim++) begin
        for (int dens = 0; dens < 2; dens++) begin
          do_clear();
          decrement_mode = md[0];
          debounce_limit = 8'(lim);
          for (int k = 0; k < 60; k++) begin
            bit c;
            lfsr = lfsr_next(lfsr);
            c = (dens == 0) ? (lfsr[1] | lfsr[0]) : lfsr[0];
            if (lim == 0)   do_tick(c, "R7 limit0 follow");
            else if (md==0) do_tick(c, "R2/R4 clear-mode sweep");
            else            do_tick(c, "R2/R5 decr-mode sweep");
          end
        end
      end
    end

    // R3: limit 255, rise exactly on 255th hit
    do_clear();
    decrement_mode = 1'b0;
    debounce_limit = 8'd255;
    for (int k = 1; k <= 300; k++) do_tick(1'b1, (k < 255) ? "R3 below 255" : "R3 at/over 255");

    // R3/R5: overrun limit 3, then exactly three misses release the flag
    do_clear();
    decrement_mode = 1'b1;
    debounce_limit = 8'd3;
    for (int k = 0; k < 10; k++) do_tick(1'b1, "R3 overrun");
    do_tick(1'b0, "R5 miss 1 holds");
    do_tick(1'b0, "R5 miss 2 holds");
    do_tick(1'b0, "R3 miss 3 releases");
    do_tick(1'b0, "R5 floor at zero");
    do_tick(1'b1, "R5 regrow 1");
    do_tick(1'b1, "R5 regrow 2");
    do_tick(1'b1, "R2 regrow 3");

    // R6: clear between ticks, then full count needed again
    do_clear();
    do_tick(1'b1, "R6 after clear 1");
    do_tick(1'b1, "R6 after clear 2");
    do_tick(1'b1, "R6 after clear 3");
    // R6: clear coinciding with a hit tick wins
    @(negedge clk);
    raw_event = 1'b1;
    sample_tick = 1'b1;
    seq_clear = 1'b1;
    @(negedge clk);
    sample_tick = 1'b0;
    seq_clear = 1'b0;
    m_cnt = 0;
    m_flag = 1'b0;
    check("R6 clear beats tick", 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule